// File: doc/BRIEF.md
# Prescaled four-channel PWM timer

The block generates four independent pulse-width modulated outputs from one clock. Each channel owns a small register slot holding an enable flag, a control word (prescaler code and output inversion), a duty value and a terminal count. A per-channel prescaler divides the clock by one of eight fixed ratios. The divided tick drives a 16-bit period counter, and the channel output is the comparison of that counter against the duty value.

Software programs a channel while it is idle and then sets the enable bit. Changes to duty, terminal count or prescaler made while the channel runs are held in the slot and applied cleanly at the next period boundary, so a running waveform never shows a torn period. Inversion applies at once.

Top module: `pwm4_timer`

## Requirements
- R1: After reset every register of every channel reads zero and all four outputs are low.
- R2: The bus uses word addresses. Bits [3:2] pick the channel, so each channel's slot starts at byte offset channel×0x10. Bits [1:0] pick the word: 0 is enable (bit 0), 1 is control (bits [2:0] prescaler code, bit 3 invert), 2 is duty (16 bits) and 3 is terminal count (16 bits). Unimplemented bits read back as zero.
- R3: Prescaler codes 0 through 7 divide the clock by 1, 4, 8, 16, 64, 256, 1024 and 4096.
- R4: With terminal count T, ratio N and normal polarity, the output is high in clock j (counting from 0 at the first cycle after the enable write) exactly when floor(j/N) mod T is below the duty value.
- R5: A duty value of zero gives a constant inactive output, and a duty value at or above T gives a constant active output.
- R6: Setting the invert bit inverts the output from the first cycle after the control write, including while the channel is disabled.
- R7: A disabled channel drives its inactive level: low, or high when the invert bit is set. Enabling it again restarts the prescaler and counter from zero.
- R8: Duty, terminal count and prescaler writes to a running channel take effect at the next period boundary. While the channel is disabled they take effect immediately.
- R9: Writing one channel's slot leaves the registers and output of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_waddr | input | 4 | Word address: channel in [3:2], register in [1:0] |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_waddr, combinational |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A register write lands on the clock edge that samples it. Read data follows the address within the same cycle. An enable write makes cycle j = 0 of the waveform the cycle right after that edge. An inversion change shows in that same cycle. A deferred duty write first shows at the first period boundary after its edge. The bench records the cycle number of every write edge and computes each expected output bit from that cycle number with the R4 formula. It queues one expected vector per future cycle, and the monitor compares each vector half a clock after its edge. An early or late period boundary, prescaler tick or load therefore shows up as a mismatch in a named cycle.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;

    localparam int unsigned PS_CODE_W = 3;
    localparam int unsigned PS_CNT_W  = 12;

    typedef enum logic [1:0] {
        SLOT_ENABLE = 2'd0,
        SLOT_CTRL   = 2'd1,
        SLOT_DUTY   = 2'd2,
        SLOT_PERIOD = 2'd3
    } slot_word_e;

    // Terminal value of the prescaler counter (ratio minus one).
    function automatic logic [PS_CNT_W-1:0] ps_limit(input logic [PS_CODE_W-1:0] code);
        logic [PS_CNT_W:0] ratio;
        case (code)
            3'd0:    ratio = 13'd1;
            3'd1:    ratio = 13'd1 << 2;
            3'd2:    ratio = 13'd1 << 3;
            3'd3:    ratio = 13'd1 << 4;
            3'd4:    ratio = 13'd1 << 6;
            3'd5:    ratio = 13'd1 << 8;
            3'd6:    ratio = 13'd1 << 10;
            default: ratio = 13'd1 << 12;
        endcase
        ps_limit = PS_CNT_W'(ratio - 13'd1);
    endfunction

endpackage

// File: rtl/pwm4_regslot.sv
module pwm4_regslot
    import pwm4_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [1:0]           word_sel,
    input  logic [CNT_W-1:0]     wr_data,
    output logic [CNT_W-1:0]     rd_data,
    output logic                 run,
    output logic                 invert,
    output logic [PS_CODE_W-1:0] presc,
    output logic [CNT_W-1:0]     duty,
    output logic [CNT_W-1:0]     period
);

    typedef struct packed {
        logic                 run;
        logic                 invert;
        logic [PS_CODE_W-1:0] presc;
        logic [CNT_W-1:0]     duty;
        logic [CNT_W-1:0]     period;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (wr_en) begin
            case (slot_word_e'(word_sel))
                SLOT_ENABLE: slot_d.run = wr_data[0];
                SLOT_CTRL: begin
                    slot_d.presc  = wr_data[PS_CODE_W-1:0];
                    slot_d.invert = wr_data[PS_CODE_W];
                end
                SLOT_DUTY:   slot_d.duty   = wr_data;
                default:     slot_d.period = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    always_comb begin
        rd_data = '0;
        case (slot_word_e'(word_sel))
            SLOT_ENABLE: rd_data[0] = slot_q.run;
            SLOT_CTRL:   rd_data[PS_CODE_W:0] = {slot_q.invert, slot_q.presc};
            SLOT_DUTY:   rd_data = slot_q.duty;
            default:     rd_data = slot_q.period;
        endcase
    end

    assign run    = slot_q.run;
    assign invert = slot_q.invert;
    assign presc  = slot_q.presc;
    assign duty   = slot_q.duty;
    assign period = slot_q.period;

endmodule

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler
    import pwm4_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic [PS_CODE_W-1:0] code,
    output logic                 tick
);

    logic [PS_CNT_W-1:0] div_d, div_q;
    logic [PS_CNT_W-1:0] limit;

    assign limit = ps_limit(code);
    assign tick  = run && (div_q == limit);

    always_comb begin
        div_d = div_q + 1'b1;
        if (!run || div_q == limit) div_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/pwm4_chan_core.sv
module pwm4_chan_core
    import pwm4_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 invert,
    input  logic [PS_CODE_W-1:0] sh_presc,
    input  logic [CNT_W-1:0]     sh_duty,
    input  logic [CNT_W-1:0]     sh_period,
    output logic                 wave,
    output logic [CNT_W-1:0]     count,
    output logic [CNT_W-1:0]     live_duty,
    output logic [CNT_W-1:0]     live_period
);

    typedef struct packed {
        logic [PS_CODE_W-1:0] presc;
        logic [CNT_W-1:0]     duty;
        logic [CNT_W-1:0]     period;
        logic [CNT_W-1:0]     count;
    } core_t;

    core_t core_d, core_q;
    logic  tick;
    logic  last_step;

    pwm4_prescaler u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (core_q.presc),
        .tick  (tick)
    );

    // Counter sits on its final value when count+1 reaches the period.
    assign last_step = ({1'b0, core_q.count} + 1'b1) >= {1'b0, core_q.period};

    always_comb begin
        core_d = core_q;
        if (!run) begin
            core_d.count  = '0;
            core_d.presc  = sh_presc;
            core_d.duty   = sh_duty;
            core_d.period = sh_period;
        end else if (tick) begin
            if (last_step) begin
                core_d.count  = '0;
                core_d.presc  = sh_presc;
                core_d.duty   = sh_duty;
                core_d.period = sh_period;
            end else begin
                core_d.count = core_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign wave        = run ? ((core_q.count < core_q.duty) ^ invert) : invert;
    assign count       = core_q.count;
    assign live_duty   = core_q.duty;
    assign live_period = core_q.period;

endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer
    import pwm4_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    parameter int unsigned CNT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_wr,
    input  logic [$clog2(NCH)+1:0]        bus_waddr,
    input  logic [CNT_W-1:0]              bus_wdata,
    output logic [CNT_W-1:0]              bus_rdata,
    output logic [NCH-1:0]                pwm_out
);

    localparam int unsigned SEL_W  = $clog2(NCH);
    localparam int unsigned ADDR_W = SEL_W + 2;

    logic [SEL_W-1:0]            ch_sel;
    logic [1:0]                  word_sel;
    logic [NCH-1:0][CNT_W-1:0]   slot_rd;
    logic [NCH-1:0]              chan_en;
    logic [NCH-1:0]              chan_inv;
    logic [NCH-1:0][CNT_W-1:0]   chan_cnt;
    logic [NCH-1:0][CNT_W-1:0]   act_duty;
    logic [NCH-1:0][CNT_W-1:0]   act_tcnt;

    assign ch_sel   = bus_waddr[ADDR_W-1:2];
    assign word_sel = bus_waddr[1:0];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [PS_CODE_W-1:0] presc;
        logic [CNT_W-1:0]     duty;
        logic [CNT_W-1:0]     period;

        pwm4_regslot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && (ch_sel == SEL_W'(g))),
            .word_sel (word_sel),
            .wr_data  (bus_wdata),
            .rd_data  (slot_rd[g]),
            .run      (chan_en[g]),
            .invert   (chan_inv[g]),
            .presc    (presc),
            .duty     (duty),
            .period   (period)
        );

        pwm4_chan_core #(.CNT_W(CNT_W)) u_core (
            .clk         (clk),
            .rst_n       (rst_n),
            .run         (chan_en[g]),
            .invert      (chan_inv[g]),
            .sh_presc    (presc),
            .sh_duty     (duty),
            .sh_period   (period),
            .wave        (pwm_out[g]),
            .count       (chan_cnt[g]),
            .live_duty   (act_duty[g]),
            .live_period (act_tcnt[g])
        );
    end

    assign bus_rdata = slot_rd[ch_sel];

endmodule

// File: rtl/pwm4_timer_chk.sv
module pwm4_timer_chk #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned ADDR_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_wr,
    input logic [ADDR_W-1:0]           bus_waddr,
    input logic                        wr_inv,
    input logic [CNT_W-1:0]            bus_rdata,
    input logic [NCH-1:0]              pwm_out,
    input logic [NCH-1:0]              chan_en,
    input logic [NCH-1:0]              chan_inv,
    input logic [NCH-1:0][CNT_W-1:0]   chan_cnt,
    input logic [NCH-1:0][CNT_W-1:0]   act_duty,
    input logic [NCH-1:0][CNT_W-1:0]   act_tcnt
);

    logic [ADDR_W-3:0] sel;
    assign sel = bus_waddr[ADDR_W-1:2];

    // R2
    enable_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_waddr[1:0] == 2'd0) |-> (bus_rdata == CNT_W'(chan_en[sel])));

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_waddr[1:0] == 2'd1) |-> (bus_rdata[CNT_W-1:4] == '0 && bus_rdata[3] == chan_inv[sel]));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R7
        idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[g] |-> (pwm_out[g] == chan_inv[g]));

        // R7
        idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !chan_en[g] |=> (chan_cnt[g] == '0));

        // R4
        count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[g] && act_tcnt[g] != '0) |-> (chan_cnt[g] < act_tcnt[g]));

        // R4
        count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_en[g] |=> (chan_cnt[g] == $past(chan_cnt[g]) ||
                            chan_cnt[g] == $past(chan_cnt[g]) + 1'b1 ||
                            chan_cnt[g] == '0));

        // R5
        zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[g] && act_duty[g] == '0) |-> (pwm_out[g] == chan_inv[g]));

        // R5
        full_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (chan_en[g] && act_duty[g] != '0 && act_duty[g] >= act_tcnt[g]) |-> (pwm_out[g] != chan_inv[g]));

        // R6
        invert_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_waddr == ADDR_W'(g * 4 + 1)) |=> (chan_inv[g] == $past(wr_inv)));
    end

endmodule

bind pwm4_timer pwm4_timer_chk #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_waddr (bus_waddr),
    .wr_inv    (bus_wdata[3]),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out),
    .chan_en   (chan_en),
    .chan_inv  (chan_inv),
    .chan_cnt  (chan_cnt),
    .act_duty  (act_duty),
    .act_tcnt  (act_tcnt)
);

// File: tb/sim_pwm4_timer.sv
module sim_pwm4_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NEVER      = 32'h7fff_ffff;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_waddr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  pwm_out;

    pwm4_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int       due;
        logic [3:0] bits;
        string    req;
    } exp_item_t;
    exp_item_t sb_q[$];

    // bench-side channel model, kept from the requirements
    int ratio[4], tcnt[4], dold[4], dnew[4], chg[4], start[4];
    bit en[4], inv[4];

    function automatic int ratio_of(int code);
        int sh[8] = '{0, 2, 3, 4, 6, 8, 10, 12};
        return 1 << sh[code];
    endfunction

    function automatic logic exp_bit(int ch, int c);
        int j, d;
        if (!en[ch] || c < start[ch]) return inv[ch];
        j = c - start[ch];
        d = (c >= chg[ch]) ? dnew[ch] : dold[ch];
        return logic'(((j / ratio[ch]) % tcnt[ch]) < d) ^ inv[ch];
    endfunction

    // monitor: compare queued vectors half a clock after each edge
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (it.due < cyc || pwm_out !== it.bits) begin
                n_fail++;
                $display("FAIL %s cycle %0d pwm_out actual %b expected %b", it.req, it.due, pwm_out, it.bits);
            end
        end
    end

    task automatic push_run(int len, string req);
        int base;
        base = cyc;
        for (int k = 1; k <= len; k++) begin
            exp_item_t it;
            it.due = base + k;
            for (int ch = 0; ch < 4; ch++) it.bits[ch] = exp_bit(ch, base + k);
            it.req = req;
            sb_q.push_back(it);
        end
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(int ch, int off, logic [15:0] v, output int w);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_waddr = 4'(ch * 4 + off);
        bus_wdata = v;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        w = cyc;
    endtask

    task automatic rd_chk(int ch, int off, logic [15:0] exp, string req);
        @(negedge clk);
        bus_waddr = 4'(ch * 4 + off);
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read ch%0d word%0d actual %h expected %h", req, ch, off, bus_rdata, exp);
        end
    endtask

    task automatic cfg(int ch, int code, bit iv, int d, int t);
        int w;
        wr(ch, 1, 16'(code | (int'(iv) << 3)), w);
        wr(ch, 2, 16'(d), w);
        wr(ch, 3, 16'(t), w);
        ratio[ch] = ratio_of(code); inv[ch] = iv;
        tcnt[ch] = t; dold[ch] = d; dnew[ch] = d; chg[ch] = NEVER;
    endtask

    task automatic set_en(int ch, bit v);
        int w;
        wr(ch, 0, 16'(v), w);
        en[ch] = v;
        start[ch] = w;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int w;
        for (int ch = 0; ch < 4; ch++) begin
            ratio[ch] = 1; tcnt[ch] = 1; dold[ch] = 0; dnew[ch] = 0;
            chg[ch] = NEVER; start[ch] = 0; en[ch] = 0; inv[ch] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        n_chk++;
        if (pwm_out !== 4'b0000) begin
            n_fail++;
            $display("FAIL R1 pwm_out actual %b expected 0000", pwm_out);
        end
        for (int ch = 0; ch < 4; ch++)
            for (int off = 0; off < 4; off++) rd_chk(ch, off, 16'h0000, "R1");

        // R2: field widths and unimplemented bits, R9: neighbours untouched
        wr(2, 1, 16'hFFFF, w); rd_chk(2, 1, 16'h000F, "R2");
        wr(2, 2, 16'hFFFF, w); rd_chk(2, 2, 16'hFFFF, "R2");
        wr(2, 3, 16'hABCD, w); rd_chk(2, 3, 16'hABCD, "R2");
        wr(2, 0, 16'hFFFE, w); rd_chk(2, 0, 16'h0000, "R2");
        wr(2, 0, 16'h0003, w); rd_chk(2, 0, 16'h0001, "R2");
        wr(2, 0, 16'h0000, w); rd_chk(2, 0, 16'h0000, "R2");
        for (int off = 0; off < 4; off++) begin
            rd_chk(1, off, 16'h0000, "R9");
            rd_chk(3, off, 16'h0000, "R9");
        end
        wr(2, 1, 16'h0000, w);
        wr(2, 2, 16'h0000, w);
        wr(2, 3, 16'h0000, w);

        // R3 R4 R5 R6 R9: four channels with different settings at once
        cfg(0, 0, 1'b0, 2, 5);
        cfg(1, 1, 1'b1, 1, 3);
        cfg(2, 2, 1'b0, 4, 4);
        cfg(3, 0, 1'b0, 0, 4);
        rd_chk(1, 1, 16'h0009, "R2");
        for (int ch = 0; ch < 4; ch++) set_en(ch, 1'b1);
        push_run(120, "R4/R5/R9");

        // R8: duty change on a running channel waits for the period boundary
        begin
            int p, j;
            wr(0, 2, 16'd4, w);
            p = ratio[0] * tcnt[0];
            j = w - start[0];
            dold[0] = 2; dnew[0] = 4;
            chg[0] = start[0] + (j / p + 1) * p;
        end
        push_run(30, "R8");

        // R6: inversion applies at once on a running channel
        wr(0, 1, 16'h0008, w);
        inv[0] = 1'b1;
        push_run(20, "R6");

        // R7: disabled level, then restart from zero; R8: idle write applies at once
        set_en(1, 1'b0);
        push_run(10, "R7");
        begin
            wr(1, 3, 16'd2, w);
            tcnt[1] = 2;
        end
        rd_chk(1, 3, 16'd2, "R8");
        set_en(1, 1'b1);
        push_run(30, "R7/R8");

        // R3: the larger prescaler ratios on channel 3
        for (int code = 3; code < 8; code++) begin
            set_en(3, 1'b0);
            cfg(3, code, 1'b0, 1, 2);
            set_en(3, 1'b1);
            push_run(ratio_of(code) * 4 + 4, "R3");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule